// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block turns a vector of request lines into the binary index of the highest-numbered request that is active. It has no clock and no state: every output is a pure function of the current inputs. Requests, the enable input, the code outputs and both status flags are active-low. The code outputs carry the inverse of the winning index.

The basic cell is an 8-line stage. Each stage has an enable input and an enable output, so stages can be chained. The enable output of a stage is low only when that stage is enabled and none of its requests are active. It drives the enable input of the next lower-priority stage. The group-select flag is low whenever the stage is enabled and reports a request.

The top module chains `NUM_STAGES` stages. `NUM_STAGES` must be a power of two: 1 gives a single 8-line stage, 2 gives 16 lines and 8 gives 64 lines. The low three code bits combine the stage codes. The upper code bits are the inverted index of the stage that holds the winner.

Top module: `prio_enc_chain`

## Requirements
- R1: When enabled, the code output equals the bitwise inverse of the index of the winning request. Index 7 in a single stage gives `000`, and index 0 alone gives `111`.
- R2: When several requests are low at once, only the highest-numbered one decides the code. Every lower-numbered request has no effect on any output.
- R3: With `en_n` high, `code_n`, `gs_n` and `eo_n` are all high, whatever the request inputs are.
- R4: Enabled with no request low, the code is all ones, `gs_n` is high and `eo_n` is low.
- R5: Enabled with at least one request low, `gs_n` is low and `eo_n` is high.
- R6: In a chain, the external enable drives the highest stage (requests `8*(NUM_STAGES-1)` and up). Each stage's enable output feeds the stage below it.
  - The low three code bits are the active-low AND of all stage codes.
  - The upper code bits are the inverted index of the stage holding the winner. With two stages, this top bit equals the upper stage's group-select.
- R7: In a chain, `gs_n` is low when any stage's group-select is low, and `eo_n` is the enable output of stage 0.
- R8: The block holds no state. The same input vector always gives the same outputs, whatever came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_n | input | 1 | Active-low enable; high forces every output high |
| req_n | input | NUM_STAGES*8 | Active-low request lines; bit i is request i |
| code_n | output | clog2(NUM_STAGES*8) | Inverted index of the highest active request |
| gs_n | output | 1 | Low when enabled and some request is active |
| eo_n | output | 1 | Low when enabled and no request is active; drives the next lower stage |

## Verification
Every result is due in the same cycle as its stimulus, because the path has no register. The driver applies a vector just after a rising edge and pushes the expected outputs. The monitor compares them at the following falling edge, before the next vector arrives. A second pass replays earlier vectors in a different order to show that the outputs do not depend on history.

// File: rtl/pe_pkg.sv
package pe_pkg;

    localparam int STAGE_LINES = 8;
    localparam int STAGE_CW    = $clog2(STAGE_LINES);

    typedef struct packed {
        logic [STAGE_CW-1:0] code_n;
        logic                gs_n;
        logic                eo_n;
    } stage_out_t;

    typedef struct packed {
        logic                hit;
        logic [STAGE_CW-1:0] idx;
    } find_t;

    // Ascending scan: the last active line seen is the highest one.
    function automatic find_t pe_find(input logic [STAGE_LINES-1:0] lines_n);
        find_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = 0; i < STAGE_LINES; i++) begin
            if (!lines_n[i]) begin
                r.hit = 1'b1;
                r.idx = STAGE_CW'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pe_stage.sv
module pe_stage
    import pe_pkg::*;
(
    input  logic                   en_n,
    input  logic [STAGE_LINES-1:0] req_n,
    output stage_out_t             res
);

    find_t found;

    always_comb begin
        found = pe_find(req_n);
        if (en_n) begin
            res = '1;
        end else if (!found.hit) begin
            res.code_n = '1;
            res.gs_n   = 1'b1;
            res.eo_n   = 1'b0;
        end else begin
            res.code_n = ~found.idx;
            res.gs_n   = 1'b0;
            res.eo_n   = 1'b1;
        end
    end

    logic [STAGE_CW-1:0] win_idx;
    assign win_idx = ~res.code_n;

    always_comb begin
        if (en_n) begin
            AST_OFF_ALL_HIGH: assert (&{res.code_n, res.gs_n, res.eo_n}); // R3
        end
        AST_FLAGS_EXCLUSIVE: assert (res.gs_n || res.eo_n); // R5
        if (!res.eo_n) begin
            AST_IDLE_CODE: assert (&res.code_n && &req_n); // R4
        end
        if (!res.gs_n) begin
            AST_WINNER_LIVE: assert (!req_n[win_idx]); // R1
            AST_NONE_ABOVE: assert (&(req_n | ((STAGE_LINES'(2) << win_idx) - STAGE_LINES'(1)))); // R2
        end
    end

endmodule

// File: rtl/prio_enc_chain.sv
module prio_enc_chain
    import pe_pkg::*;
#(
    parameter  int NUM_STAGES = 2,
    localparam int LINES      = NUM_STAGES * STAGE_LINES,
    localparam int CW         = $clog2(LINES)
) (
    input  logic             en_n,
    input  logic [LINES-1:0] req_n,
    output logic [CW-1:0]    code_n,
    output logic             gs_n,
    output logic             eo_n
);

    // en_chain[s+1] enables stage s; stage s drives en_chain[s].
    logic [NUM_STAGES:0]   en_chain;
    logic [NUM_STAGES-1:0] stage_gs_n;
    stage_out_t            so [NUM_STAGES];
    logic [STAGE_CW-1:0]   low_code_n;

    assign en_chain[NUM_STAGES] = en_n;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        pe_stage u_stg (
            .en_n  (en_chain[s+1]),
            .req_n (req_n[s*STAGE_LINES +: STAGE_LINES]),
            .res   (so[s])
        );
        assign en_chain[s]   = so[s].eo_n;
        assign stage_gs_n[s] = so[s].gs_n;
    end

    always_comb begin
        low_code_n = '1;
        for (int s = 0; s < NUM_STAGES; s++) begin
            low_code_n = low_code_n & so[s].code_n;
        end
    end

    if (NUM_STAGES > 1) begin : g_group
        localparam int SW = CW - STAGE_CW;
        logic [SW-1:0] grp_code_n;
        always_comb begin
            grp_code_n = '1;
            for (int s = 0; s < NUM_STAGES; s++) begin
                if (!so[s].gs_n) grp_code_n = grp_code_n & ~SW'(s);
            end
        end
        assign code_n = {grp_code_n, low_code_n};
    end else begin : g_single
        assign code_n = low_code_n;
    end

    assign gs_n = &stage_gs_n;
    assign eo_n = en_chain[0];

    always_comb begin
        AST_ONE_GROUP: assert ($onehot0(~stage_gs_n)); // R6
        if (!gs_n) begin
            AST_CHAIN_FLAGS: assert (eo_n); // R7
        end
        if (en_n) begin
            AST_CHAIN_OFF: assert (&{code_n, gs_n, eo_n}); // R3
        end
    end

endmodule

// File: tb/sim_prio_enc_chain.sv
module sim_prio_enc_chain;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    typedef struct {
        logic [5:0]  code;
        logic        gs;
        logic        eo;
        logic        en;
        logic [63:0] vec;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // u0: 16 lines, u1: single stage, u2: 64 lines
    logic        en0, en1, en2;
    logic [15:0] req0;
    logic [7:0]  req1;
    logic [63:0] req2;
    logic [3:0]  code0;
    logic [2:0]  code1;
    logic [5:0]  code2;
    logic        gs0, gs1, gs2, eo0, eo1, eo2;

    prio_enc_chain #(.NUM_STAGES(2)) u0 (.en_n(en0), .req_n(req0), .code_n(code0), .gs_n(gs0), .eo_n(eo0));
    prio_enc_chain #(.NUM_STAGES(1)) u1 (.en_n(en1), .req_n(req1), .code_n(code1), .gs_n(gs1), .eo_n(eo1));
    prio_enc_chain #(.NUM_STAGES(8)) u2 (.en_n(en2), .req_n(req2), .code_n(code2), .gs_n(gs2), .eo_n(eo2));

    exp_t q0[$];
    exp_t q1[$];
    exp_t q2[$];
    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    function automatic exp_t ref_enc(input logic en, input logic [63:0] vec,
                                     input int lines, input int cw, input string tag);
        exp_t e;
        int h = -1;
        logic [5:0] mask = 6'((64'd1 << cw) - 1);
        for (int i = 0; i < lines; i++) if (!vec[i]) h = i;
        e.en = en; e.vec = vec; e.tag = tag;
        if (en) begin
            e.code = mask; e.gs = 1; e.eo = 1;
        end else if (h < 0) begin
            e.code = mask; e.gs = 1; e.eo = 0;
        end else begin
            e.code = (~6'(h)) & mask; e.gs = 0; e.eo = 1;
        end
        return e;
    endfunction

    function automatic string stage_tag(input logic en, input logic [7:0] vec);
        int n = 0;
        for (int i = 0; i < 8; i++) if (!vec[i]) n++;
        if (en)     return "R3";
        if (n == 0) return "R4";
        if (n > 1)  return "R2,R5";
        return "R1,R5";
    endfunction

    task automatic drive(input int k, input bit replay);
        en0  = k[16];
        req0 = k[15:0];
        q0.push_back(ref_enc(en0, {48'hFFFF_FFFF_FFFF, req0}, 16, 4, replay ? "R8" : "R6,R7"));
        if (!replay) begin
            en1  = k[8];
            req1 = k[7:0];
            q1.push_back(ref_enc(en1, {56'hFF_FFFF_FFFF_FFFF, req1}, 8, 3, stage_tag(en1, req1)));
            en2  = k[13] & k[12];
            req2 = (k[13:12] == 2'b10) ? '1 :
                   ~((64'd1 << k[5:0]) | (64'd1 << k[11:6]));
            q2.push_back(ref_enc(en2, req2, 64, 6, "R6,R7"));
        end
    endtask

    task automatic compare(input string who, input exp_t e,
                           input logic [5:0] code, input logic gs, input logic eo);
        checks++;
        if (code !== e.code || gs !== e.gs || eo !== e.eo) begin
            failures++;
            $display("FAIL %s %s en=%b req=%h got code=%h gs=%b eo=%b exp code=%h gs=%b eo=%b",
                     e.tag, who, e.en, e.vec, code, gs, eo, e.code, e.gs, e.eo);
        end
    endtask

    // Monitor: combinational results are due in the same cycle as the stimulus.
    always @(negedge clk) begin
        if (q0.size() > 0) compare("u0", q0.pop_front(), {2'b00, code0}, gs0, eo0);
        if (q1.size() > 0) compare("u1", q1.pop_front(), {3'b000, code1}, gs1, eo1);
        if (q2.size() > 0) compare("u2", q2.pop_front(), code2, gs2, eo2);
    end

    initial begin
        en0 = 1'b1; req0 = '1; en1 = 1'b1; req1 = '1; en2 = 1'b1; req2 = '1;
        @(posedge clk);
        // Idle state after start: disabled, nothing requested (R3)
        q0.push_back(ref_enc(1'b1, '1, 16, 4, "R3"));
        q1.push_back(ref_enc(1'b1, '1, 8, 3, "R3"));
        q2.push_back(ref_enc(1'b1, '1, 64, 6, "R3"));
        for (int k = 0; k < (1 << 17); k++) begin
            @(posedge clk);
            drive(k, 1'b0);
        end
        // R8: replay earlier vectors in another order
        for (int k = 255; k >= 0; k--) begin
            @(posedge clk);
            drive(k * 511, 1'b1);
        end
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule